// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM that has 8 data bits and 18 address bits. The host hands over one word at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The controller then plays out the strobe sequence the memory needs: two chip enables of opposite polarity, an output enable and a write enable. Read results come back in a data register, marked by a single-cycle valid pulse.

The memory has no clock, so every phase is timed by counting cycles of the controller's clock. The clock period is a parameter, and so is each of the memory's minimum nanosecond limits. Each phase length is the ceiling of its governing limit divided by the period, and never less than one cycle. The shared data bus is split into an output value, an output enable and an input value, for a pad cell elsewhere on the chip. The controller only drives the bus while write enable is low. After a read it waits long enough for the memory's own drivers to turn off before any write can drive the bus.

Top module: `sram_ctl`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it is released, chip enable 1 is high, chip enable 2 is low, output enable and write enable are high, the bus driver is off, `rsp_valid` is low and `req_ready` is high.
- R2: When idle, the memory is deselected, the bus driver is off and `req_ready` is high. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- R3: A read starts on the edge after acceptance and holds the memory selected (chip enable 1 low, chip enable 2 high) with output enable low, write enable high and the accepted address. This lasts for ceil(max(45, 45, 45, 22) ns / period) cycles, which is 6 cycles at 8 ns. The data bus is sampled at the edge that ends this phase.
- R4: At the edge that ends the read phase, `rsp_valid` goes high for exactly one cycle, and `rsp_rdata` then carries the sampled word.
- R5: A write starts on the edge after acceptance. Output enable stays high throughout. Write enable stays low for ceil(max(35, 35, 25) ns / period) cycles, which is 5 at 8 ns. The device then stays selected with write enable high until ceil(45 ns / period) cycles have passed in total, with at least one such cycle, which gives 1 at 8 ns.
- R6: The bus driver is on only while write enable is low and the device is selected. While it is on, it carries the accepted write data. Output enable and write enable are never low together, and the address does not change while the device stays selected.
- R7: After every read, the device is deselected with output enable high and the bus released for ceil(18 ns / period) cycles (3 at 8 ns) before the controller returns to idle. The bus driver therefore never overlaps the memory's own output-disable window.
- R8: From acceptance until an operation ends, `req_ready` is low: 6 cycles for a write and 9 for a read at 8 ns. A `req_valid` raised during that time has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Last word read |
| mem_addr | output | 18 | Memory address pins |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Value seen on the data bus |

## Verification
The checker assumes only that reset is applied before the first edge it watches. It assumes nothing about the host's request fields or about the memory. Its properties are therefore written purely in terms of the strobe outputs and the handshake. The stimulus keeps the host honest in the sense the block relies on. Inputs change only at falling edges, `req_valid` is dropped in the same half cycle in which `req_ready` is seen high whenever an ignored request is being tested, and the bench's memory model returns a poison value until the full access time has passed. The bench's memory model also refuses writes whose pulse is shorter than the 35 ns minimum.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_TA,
        ST_WR_PULSE,
        ST_WR_REC
    } st_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Whole cycles covering a nanosecond limit, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned q;
        q = (ns + period - 1) / period;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic strobe_t strobes_for(input st_e s);
        strobe_t r;
        r.ce1_n = 1'b1;
        r.ce2   = 1'b0;
        r.oe_n  = 1'b1;
        r.we_n  = 1'b1;
        r.dq_oe = 1'b0;
        case (s)
            ST_RD: begin
                r.ce1_n = 1'b0;
                r.ce2   = 1'b1;
                r.oe_n  = 1'b0;
            end
            ST_WR_PULSE: begin
                r.ce1_n = 1'b0;
                r.ce2   = 1'b1;
                r.we_n  = 1'b0;
                r.dq_oe = 1'b1;
            end
            ST_WR_REC: begin
                r.ce1_n = 1'b0;
                r.ce2   = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned N_RD   = 6,
    parameter int unsigned N_TA   = 3,
    parameter int unsigned N_PWE  = 5,
    parameter int unsigned N_WREC = 1,
    parameter int unsigned CNT_W  = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  logic    acc_write,
    output st_e     state,
    output logic    last_cycle,
    output strobe_t strb
);

    st_e              state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    strobe_t          strb_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = acc_write ? ST_WR_PULSE : ST_RD;
                    cnt_d   = acc_write ? CNT_W'(N_PWE - 1) : CNT_W'(N_RD - 1);
                end
            end
            ST_RD: begin
                if (cnt_q == '0) begin
                    state_d = ST_RD_TA;
                    cnt_d   = CNT_W'(N_TA - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RD_TA: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_REC;
                    cnt_d   = CNT_W'(N_WREC - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_WR_REC: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobes are registered from the next state so the asynchronous pins never see decode glitches.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            strb_q  <= strobes_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            strb_q  <= strobes_for(state_d);
        end
    end

    assign state      = state_q;
    assign last_cycle = (cnt_q == '0);
    assign strb       = strb_q;

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            rdata_q     <= '0;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned T_CLK_NS   = 8,
    parameter int unsigned T_RC_NS    = 45,
    parameter int unsigned T_AA_NS    = 45,
    parameter int unsigned T_ACE_NS   = 45,
    parameter int unsigned T_DOE_NS   = 22,
    parameter int unsigned T_WC_NS    = 45,
    parameter int unsigned T_PWE_NS   = 35,
    parameter int unsigned T_AW_NS    = 35,
    parameter int unsigned T_SD_NS    = 25,
    parameter int unsigned T_HZ_NS    = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned N_RD   = ns_to_cyc(imax(imax(T_RC_NS, T_AA_NS), imax(T_ACE_NS, T_DOE_NS)), T_CLK_NS);
    localparam int unsigned N_PWE  = ns_to_cyc(imax(T_PWE_NS, imax(T_AW_NS, T_SD_NS)), T_CLK_NS);
    localparam int unsigned N_WC   = ns_to_cyc(T_WC_NS, T_CLK_NS);
    localparam int unsigned N_WREC = (N_WC > N_PWE) ? (N_WC - N_PWE) : 1;
    localparam int unsigned N_TA   = ns_to_cyc(T_HZ_NS, T_CLK_NS);
    localparam int unsigned N_MAX  = imax(imax(N_RD, N_TA), imax(N_PWE, N_WREC));
    localparam int unsigned CNT_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

    st_e     state;
    logic    last_cycle;
    strobe_t strb;
    logic    accept;
    logic    capture;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_RD) && last_cycle;

    sram_ctl_seq #(
        .N_RD   (N_RD),
        .N_TA   (N_TA),
        .N_PWE  (N_PWE),
        .N_WREC (N_WREC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .acc_write  (req_write),
        .state      (state),
        .last_cycle (last_cycle),
        .strb       (strb)
    );

    sram_ctl_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .capture     (capture),
        .bus_in      (mem_dq_i),
        .addr_q      (mem_addr),
        .wdata_q     (mem_dq_o),
        .rdata_q     (rsp_rdata),
        .rsp_valid_q (rsp_valid)
    );

    assign mem_ce1_n = strb.ce1_n;
    assign mem_ce2   = strb.ce2;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.dq_oe;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned N_PWE  = 5,
    parameter int unsigned N_TA   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    logic sel;
    int   we_lo_cnt;
    int   oe_hi_cnt;

    assign sel = !mem_ce1_n && mem_ce2;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= 0;
            oe_hi_cnt <= int'(N_TA);
        end else begin
            we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
            if (!mem_oe_n)                oe_hi_cnt <= 0;
            else if (oe_hi_cnt < int'(N_TA)) oe_hi_cnt <= oe_hi_cnt + 1;
        end
    end

    p_idle_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dq_oe));

    p_rsp_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_we_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt == int'(N_PWE)));

    p_no_oe_we_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    p_drive_in_write_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && sel && mem_oe_n));

    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(mem_addr));

    p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= int'(N_TA)));

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .N_PWE  (N_PWE),
    .N_TA   (N_TA)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: poison until access time has elapsed, writes need a full pulse.
    logic [7:0]  mem [logic [17:0]];
    logic        sel, m_rd;
    int          rd_age = 0, tail = 0, wcnt = 0;
    logic [7:0]  wbuf = '0;
    logic [17:0] wa = '0, last_addr = '0, prev_addr = '0;
    logic        prev_sel = 1'b0;
    int          contention = 0, drive_bad = 0, addr_bad = 0;

    assign sel  = !mem_ce1_n && mem_ce2;
    assign m_rd = sel && !mem_oe_n && mem_we_n;

    always @(posedge clk) begin
        last_addr <= mem_addr;
        if (!m_rd)                      rd_age <= 0;
        else if (mem_addr != last_addr) rd_age <= 1;
        else                            rd_age <= rd_age + 1;
        if (m_rd)          tail <= 3;
        else if (tail > 0) tail <= tail - 1;
        if (sel && !mem_we_n) begin
            wcnt <= wcnt + 1;
            wbuf <= mem_dq_oe ? mem_dq_o : 8'hA5;
            wa   <= mem_addr;
        end else if (wcnt > 0) begin
            if (wcnt * CLK_NS >= 35) mem[wa] = wbuf;
            wcnt <= 0;
        end
    end

    always_comb begin
        if (m_rd && (rd_age + 1) * CLK_NS >= 45)
            mem_dq_i = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        else
            mem_dq_i = 8'hEE;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && (m_rd || tail > 0)) contention++;
            if (mem_dq_oe && mem_we_n)           drive_bad++;
            if (sel && prev_sel && mem_addr != prev_addr) addr_bad++;
        end
        prev_sel  <= sel;
        prev_addr <= mem_addr;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        int lo = 0;
        bit oe_ok = 1, dq_ok = 1;
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        while (!mem_we_n && lo < 50) begin
            lo++;
            if (mem_oe_n !== 1'b1) oe_ok = 0;
            if (!(mem_dq_oe && mem_dq_o == d && mem_addr == a && sel)) dq_ok = 0;
            @(negedge clk);
        end
        check(lo == 5, "R5 write enable low cycles", lo, 5);
        check(oe_ok, "R5 output enable high during write", int'(oe_ok), 1);
        check(dq_ok, "R6 bus driven with write data while WE low", int'(dq_ok), 1);
        check(sel && !mem_dq_oe && mem_oe_n, "R5 recovery cycle selected, bus released",
              {sel, mem_dq_oe}, 2'b10);
        @(negedge clk);
        check(req_ready && mem_ce1_n && !mem_ce2, "R2 idle and deselected after write",
              {req_ready, mem_ce1_n, mem_ce2}, 3'b110);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
        int n = 0, ta = 0;
        bit ok = 1, ta_ok = 1;
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        while (!mem_oe_n && n < 50) begin
            n++;
            if (!(sel && mem_we_n && !mem_dq_oe && mem_addr == a && !rsp_valid)) ok = 0;
            @(negedge clk);
        end
        check(n == 6, "R3 read phase cycles", n, 6);
        check(ok, "R3 read strobes and address held", int'(ok), 1);
        check(rsp_valid == 1'b1, "R4 valid pulse at end of read", int'(rsp_valid), 1);
        check(rsp_rdata == exp, "R4 read data", rsp_rdata, exp);
        while (!req_ready && ta < 50) begin
            ta++;
            if (mem_oe_n !== 1'b1 || mem_dq_oe || !mem_ce1_n) ta_ok = 0;
            if (ta == 2 && rsp_valid) ta_ok = 0;
            @(negedge clk);
        end
        check(ta == 3, "R7 turnaround cycles after read", ta, 3);
        check(ta_ok, "R7 released and deselected during turnaround, R4 single pulse", int'(ta_ok), 1);
        check(rsp_rdata == exp, "R4 read data held", rsp_rdata, exp);
    endtask

    task automatic test_reset();
        check(mem_ce1_n && !mem_ce2, "R1 deselected after reset", {mem_ce1_n, mem_ce2}, 2'b10);
        check(mem_oe_n && mem_we_n && !mem_dq_oe, "R1 enables high, bus released",
              {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
        check(req_ready && !rsp_valid, "R1 ready high, no response", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic test_patterns();
        do_write(18'h00000, 8'h3C);
        do_write(18'h3FFFF, 8'hC3);
        do_write(18'h15555, 8'hA5);
        do_read(18'h00000, 8'h3C);
        do_read(18'h3FFFF, 8'hC3);
        do_read(18'h15555, 8'hA5);
    endtask

    task automatic test_ignore_busy();
        int busy = 0;
        bit stayed_busy = 1;
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = 18'h00200; req_wdata = 8'h77;
        @(negedge clk);
        req_addr = 18'h00300; req_wdata = 8'h99;
        while (!req_ready && busy < 50) begin
            busy++;
            @(negedge clk);
        end
        req_valid = 0;
        check(busy == 6, "R8 ready low cycles during write", busy, 6);
        if (mem_dq_oe) stayed_busy = 0;
        check(stayed_busy, "R8 no drive after ignored request", int'(stayed_busy), 1);
        do_read(18'h00300, 8'h00);
        do_read(18'h00200, 8'h77);
    endtask

    task automatic test_read_then_write();
        do_write(18'h0ABCD, 8'h5A);
        do_read(18'h0ABCD, 8'h5A);
        do_write(18'h0ABCD, 8'h81);
        do_write(18'h0ABCE, 8'h18);
        do_read(18'h0ABCD, 8'h81);
        do_read(18'h0ABCE, 8'h18);
        check(contention == 0, "R7 no bus contention with memory", contention, 0);
        check(drive_bad == 0, "R6 drive only while WE low", drive_bad, 0);
        check(addr_bad == 0, "R6 address stable while selected", addr_bad, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_patterns();
        test_ignore_busy();
        test_read_then_write();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule